// File: doc/BRIEF.md
# Page-mode DRAM access sequencer

This block sits on the host side of a 16K x 1 dynamic memory with a multiplexed address bus. It takes single-bit read and write requests over a valid/ready handshake, each with a 14-bit word address. It turns them into strobe sequences on the memory pins. For a new row, the row half of the address goes onto the pins and the row strobe falls. The row half is held for a set number of cycles. The pins then switch to the column half, and the column strobe falls. Every delay is a whole number of system clock cycles, set by a parameter.

After an access the row is left open. A later request to the same row is served by a column-strobe pulse alone. A request to another row, or a refresh grant from an outside scheduler, closes the page first. The row strobe then rises and stays high for a precharge count. A refresh is a row-strobe-only cycle on an internal row counter.

Writes are always early writes: the write-enable pin is low before the column strobe falls. The memory output therefore stays off, and one data line can serve both directions. Reads sample the memory output a fixed count after the column strobe falls. They return the bit with a one-cycle valid pulse.

Top module: `dram_page_seq`

## Requirements
- R1: After reset the sequencer is idle. `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `rd_valid` is low, and `req_ready` is high while no refresh grant is present.
- R2: With `ROW_IN_MSB`=1, address bits [13:7] are the row and bits [6:0] are the column. For a new row, the row bits are on `dram_a` when `dram_ras_n` falls. They stay there for `RAS_HOLD_CYC` cycles. The column bits then appear, and `dram_cas_n` falls exactly `RAS_HOLD_CYC`+1 cycles after `dram_ras_n` fell. `dram_a` does not change while `dram_cas_n` is low.
- R3: On a write, `dram_we_n` is already low in the cycle before `dram_cas_n` falls, and `dram_din` carries the request's data bit. A later read of that address returns the bit.
- R4: On a read, `dram_we_n` stays high for the whole time `dram_cas_n` is low. `dram_cas_n` stays low for exactly `CAS_LOW_CYC` cycles. `dram_dout` is sampled at the edge where `dram_cas_n` rises. `rd_valid` is high for one cycle, the cycle right after that edge, with `rd_data` holding the sampled bit.
- R5: A request to the open row is served with no new fall of `dram_ras_n`. This covers column 127, the last column of a row.
- R6: Between two column-strobe pulses in one page, `dram_cas_n` stays high for at least `CAS_PRE_CYC` cycles.
- R7: A request to a different row closes the page. `dram_ras_n` rises and stays high for at least `RAS_PRE_CYC` cycles. It then falls once for the new row.
- R8: A high `ref_grant` closes any open page and wins over a pending request. The sequencer runs a cycle in which `dram_ras_n` is low and `dram_cas_n` stays high. The row used comes from an internal counter that starts at 0 after reset and steps by one modulo 128. `ref_ack` pulses for one cycle once `dram_ras_n` has risen. The scheduler drops `ref_grant` when it sees `ref_ack`.
- R9: `req_ready` is high only when idle, or when a page is open and the offered address hits that page. It is low while a request to another row is offered to an open page. No request is accepted while `dram_cas_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*PIN_W | Word address (row and column halves) |
| req_wdata | input | 1 | Write data bit |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 1 | Read data bit |
| ref_grant | input | 1 | Refresh request from outside scheduler |
| ref_ack | output | 1 | One-cycle pulse when a refresh cycle is done |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_a | output | PIN_W | Multiplexed address pins |
| dram_din | output | 1 | Data to the memory |
| dram_dout | input | 1 | Data from the memory |

## Verification
The bench builds the block with a row hold of 2, a column-strobe low time of 4, a column precharge of 3, a row precharge of 5 and a refresh low time of 6. The counts all differ, so a counter loaded with the wrong count, or a state that skips its counter, shows up as a wrong strobe width or a wrong rise-to-fall spacing. The counts are also short enough that the refresh row counter can run through all 128 rows and wrap within the run. Address bits stay at the default of 7 per half, with the row in the upper bits. Columns 0 and 127 and rows 2, 84 and 127 are used. A shadow memory model in the bench stores the data on early writes and drives the read bit.

// File: rtl/dps_pkg.sv
package dps_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ROW_SET,
      ST_RAS_HOLD,
      ST_COL_SET,
      ST_CAS_ACT,
      ST_CAS_PRE,
      ST_PAGE,
      ST_RAS_PRE,
      ST_REF_SET,
      ST_REF_ACT
   } seq_state_e;

endpackage

// File: rtl/dps_delay_cnt.sv
module dps_delay_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // R6: an expired count stays expired until reloaded
   a_r6_cnt_rests: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && expired) |=> expired);

endmodule

// File: rtl/dps_open_row.sv
module dps_open_row #(
   parameter int PIN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_en,
   input  logic [PIN_W-1:0] open_row,
   input  logic             close_en,
   input  logic [PIN_W-1:0] probe_row,
   output logic             row_hit
);

   logic             open_q;
   logic [PIN_W-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (open_en) begin
         open_q <= 1'b1;
         row_q  <= open_row;
      end else if (close_en) begin
         open_q <= 1'b0;
      end
   end

   assign row_hit = open_q && (row_q == probe_row);

   // R5: a page is never opened and closed in the same cycle
   a_r5_open_close_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(open_en && close_en));

endmodule

// File: rtl/dps_ref_row.sv
module dps_ref_row #(
   parameter int PIN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [PIN_W-1:0] ref_row
);

   logic [PIN_W-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         row_q <= '0;
      else if (advance)
         row_q <= row_q + 1'b1;
   end

   assign ref_row = row_q;

   // R8: the refresh row only moves when a refresh completes
   a_r8_ref_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(row_q));

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq #(
   parameter int PIN_W        = 7,
   parameter bit ROW_IN_MSB   = 1'b1,
   parameter int CNT_W        = 8,
   parameter int RAS_HOLD_CYC = 1,
   parameter int CAS_LOW_CYC  = 5,
   parameter int CAS_PRE_CYC  = 3,
   parameter int RAS_PRE_CYC  = 5,
   parameter int REF_LOW_CYC  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [2*PIN_W-1:0]   req_addr,
   input  logic                 req_wdata,
   output logic                 rd_valid,
   output logic                 rd_data,
   input  logic                 ref_grant,
   output logic                 ref_ack,
   output logic                 dram_ras_n,
   output logic                 dram_cas_n,
   output logic                 dram_we_n,
   output logic [PIN_W-1:0]     dram_a,
   output logic                 dram_din,
   input  logic                 dram_dout
);
   import dps_pkg::*;

   localparam int CNT_MAX = (1 << CNT_W) - 1;
   localparam logic [CNT_W-1:0] L_RAH  = CNT_W'(RAS_HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] L_CASL = CNT_W'(CAS_LOW_CYC - 1);
   localparam logic [CNT_W-1:0] L_CASP = CNT_W'(CAS_PRE_CYC - 1);
   localparam logic [CNT_W-1:0] L_RP   = CNT_W'(RAS_PRE_CYC - 1);
   localparam logic [CNT_W-1:0] L_REF  = CNT_W'(REF_LOW_CYC - 1);

   // elaboration-time parameter checks
   if (PIN_W < 1) begin : g_bad_pin_w
      $error("PIN_W must be at least 1");
   end
   if (RAS_HOLD_CYC < 1 || RAS_HOLD_CYC > CNT_MAX) begin : g_bad_rah
      $error("RAS_HOLD_CYC out of counter range");
   end
   if (CAS_LOW_CYC < 1 || CAS_LOW_CYC > CNT_MAX) begin : g_bad_casl
      $error("CAS_LOW_CYC out of counter range");
   end
   if (CAS_PRE_CYC < 1 || CAS_PRE_CYC > CNT_MAX) begin : g_bad_casp
      $error("CAS_PRE_CYC out of counter range");
   end
   if (RAS_PRE_CYC < 1 || RAS_PRE_CYC > CNT_MAX) begin : g_bad_rp
      $error("RAS_PRE_CYC out of counter range");
   end
   if (REF_LOW_CYC < 1 || REF_LOW_CYC > CNT_MAX) begin : g_bad_ref
      $error("REF_LOW_CYC out of counter range");
   end

   // address split: the row half sits high or low in the request word
   logic [PIN_W-1:0] req_row, req_col;
   if (ROW_IN_MSB) begin : g_row_msb
      assign req_row = req_addr[2*PIN_W-1:PIN_W];
      assign req_col = req_addr[PIN_W-1:0];
   end else begin : g_row_lsb
      assign req_row = req_addr[PIN_W-1:0];
      assign req_col = req_addr[2*PIN_W-1:PIN_W];
   end

   seq_state_e       st_q, st_d;
   logic             cnt_load, expired;
   logic [CNT_W-1:0] cnt_val;
   logic             accept, open_en, close_en, row_hit, ref_done;
   logic [PIN_W-1:0] ref_row;
   logic [PIN_W-1:0] cur_row, cur_col;
   logic             cur_wr, cur_wd;
   logic             rd_valid_q, rd_data_q, ref_ack_q;

   dps_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .expired  (expired)
   );

   dps_open_row #(.PIN_W(PIN_W)) u_page (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_en   (open_en),
      .open_row  (req_row),
      .close_en  (close_en),
      .probe_row (req_row),
      .row_hit   (row_hit)
   );

   dps_ref_row #(.PIN_W(PIN_W)) u_ref (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (ref_done),
      .ref_row (ref_row)
   );

   assign req_ready = !ref_grant &&
                      ((st_q == ST_IDLE) || ((st_q == ST_PAGE) && row_hit));
   assign ref_done  = (st_q == ST_REF_ACT) && expired;

   always_comb begin
      st_d     = st_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      accept   = 1'b0;
      open_en  = 1'b0;
      close_en = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (ref_grant) begin
               st_d = ST_REF_SET;
            end else if (req_valid) begin
               st_d    = ST_ROW_SET;
               accept  = 1'b1;
               open_en = 1'b1;
            end
         end
         ST_ROW_SET: begin
            st_d     = ST_RAS_HOLD;
            cnt_load = 1'b1;
            cnt_val  = L_RAH;
         end
         ST_RAS_HOLD: begin
            if (expired) st_d = ST_COL_SET;
         end
         ST_COL_SET: begin
            st_d     = ST_CAS_ACT;
            cnt_load = 1'b1;
            cnt_val  = L_CASL;
         end
         ST_CAS_ACT: begin
            if (expired) begin
               st_d     = ST_CAS_PRE;
               cnt_load = 1'b1;
               cnt_val  = L_CASP;
            end
         end
         ST_CAS_PRE: begin
            if (expired) st_d = ST_PAGE;
         end
         ST_PAGE: begin
            if (ref_grant || (req_valid && !row_hit)) begin
               st_d     = ST_RAS_PRE;
               cnt_load = 1'b1;
               cnt_val  = L_RP;
               close_en = 1'b1;
            end else if (req_valid) begin
               st_d   = ST_COL_SET;
               accept = 1'b1;
            end
         end
         ST_RAS_PRE: begin
            if (expired) st_d = ST_IDLE;
         end
         ST_REF_SET: begin
            st_d     = ST_REF_ACT;
            cnt_load = 1'b1;
            cnt_val  = L_REF;
         end
         ST_REF_ACT: begin
            if (expired) begin
               st_d     = ST_RAS_PRE;
               cnt_load = 1'b1;
               cnt_val  = L_RP;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cur_row    <= '0;
         cur_col    <= '0;
         cur_wr     <= 1'b0;
         cur_wd     <= 1'b0;
         rd_valid_q <= 1'b0;
         rd_data_q  <= 1'b0;
         ref_ack_q  <= 1'b0;
      end else begin
         st_q       <= st_d;
         rd_valid_q <= 1'b0;
         ref_ack_q  <= ref_done;
         if (accept) begin
            cur_row <= req_row;
            cur_col <= req_col;
            cur_wr  <= req_write;
            cur_wd  <= req_wdata;
         end
         if ((st_q == ST_CAS_ACT) && expired && !cur_wr) begin
            rd_valid_q <= 1'b1;
            rd_data_q  <= dram_dout;
         end
      end
   end

   // pin decode
   always_comb begin
      dram_ras_n = 1'b1;
      dram_cas_n = 1'b1;
      dram_we_n  = 1'b1;
      dram_a     = cur_col;
      case (st_q)
         ST_IDLE, ST_ROW_SET, ST_RAS_PRE: dram_a = cur_row;
         ST_RAS_HOLD: begin
            dram_ras_n = 1'b0;
            dram_a     = cur_row;
         end
         ST_COL_SET: begin
            dram_ras_n = 1'b0;
            dram_we_n  = !cur_wr;
         end
         ST_CAS_ACT: begin
            dram_ras_n = 1'b0;
            dram_cas_n = 1'b0;
            dram_we_n  = !cur_wr;
         end
         ST_CAS_PRE, ST_PAGE: dram_ras_n = 1'b0;
         ST_REF_SET: dram_a = ref_row;
         ST_REF_ACT: begin
            dram_ras_n = 1'b0;
            dram_a     = ref_row;
         end
         default: ;
      endcase
   end

   assign dram_din = cur_wd;
   assign rd_valid = rd_valid_q;
   assign rd_data  = rd_data_q;
   assign ref_ack  = ref_ack_q;

   // R2: column strobe only inside an open row
   a_r2_cas_in_row: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) |-> !dram_ras_n);
   // R2: address pins frozen while the column strobe is low
   a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> $stable(dram_a));
   // R3: write enable leads the column strobe
   a_r3_early_write: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_cas_n) && !dram_we_n) |-> ($past(dram_we_n) == 1'b0));
   // R4: write enable does not move while the column strobe is low
   a_r4_we_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && !$fell(dram_cas_n)) |-> $stable(dram_we_n));
   // R4: read valid is a single-cycle pulse
   a_r4_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   // R5: a page hit keeps the row strobe low
   a_r5_hit_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !dram_ras_n) |=> !dram_ras_n);
   // R7: row precharge lasts more than one cycle
   a_r7_row_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ras_n) |=> dram_ras_n);
   // R8: refresh ack arrives with both strobes high
   a_r8_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ref_ack |-> (dram_ras_n && dram_cas_n));
   // R9: no request taken while the column strobe is low
   a_r9_no_take_cas: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> dram_cas_n);

endmodule

// File: tb/sim_dram_page_seq.sv
module sim_dram_page_seq;

   localparam int CLK_PERIOD = 10;
   localparam int PW   = 7;
   localparam int RAH  = 2;
   localparam int CASL = 4;
   localparam int CASP = 3;
   localparam int RP   = 5;
   localparam int REFL = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_ready;
   logic           req_write = 1'b0;
   logic [2*PW-1:0] req_addr = '0;
   logic           req_wdata = 1'b0;
   logic           rd_valid, rd_data;
   logic           ref_grant = 1'b0;
   logic           ref_ack;
   logic           dram_ras_n, dram_cas_n, dram_we_n;
   logic [PW-1:0]  dram_a;
   logic           dram_din, dram_dout;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_page_seq #(
      .PIN_W(PW), .ROW_IN_MSB(1'b1), .CNT_W(8),
      .RAS_HOLD_CYC(RAH), .CAS_LOW_CYC(CASL), .CAS_PRE_CYC(CASP),
      .RAS_PRE_CYC(RP), .REF_LOW_CYC(REFL)
   ) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .ref_grant(ref_grant), .ref_ack(ref_ack),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_a(dram_a), .dram_din(dram_din), .dram_dout(dram_dout)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // memory model, sampled at the falling clock edge
   logic mem_m [int];
   logic sh    [int];
   int   ras_falls = 0, cas_rises = 0;
   int   ras_low_cnt = 0, ras_high_cnt = 0, cas_low_cnt = 0, cas_high_cnt = 0;
   bit   first_cas = 1'b0, cas_seen = 1'b0;
   logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, we_at_fall = 1'b1;
   logic [PW-1:0] m_row = '0, m_col = '0;
   logic m_rd = 1'b0;

   assign dram_dout = (!dram_cas_n && dram_we_n) ? m_rd : 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_ras && !dram_ras_n) begin
            ras_falls++;
            if (ras_falls > 1)
               check(ras_high_cnt >= RP, "R7 row precharge", ras_high_cnt, RP);
            m_row       = dram_a;
            ras_low_cnt = 0;
            first_cas   = 1'b1;
            cas_seen    = 1'b0;
         end else if (!dram_ras_n) begin
            ras_low_cnt++;
         end else if (!p_ras) begin
            ras_high_cnt = 1;
         end else begin
            ras_high_cnt++;
         end
         if (!dram_ras_n && first_cas && ras_low_cnt < RAH)
            check(dram_a == m_row, "R2 row held", int'(dram_a), int'(m_row));
         if (p_cas && !dram_cas_n) begin
            m_col       = dram_a;
            cas_seen    = 1'b1;
            we_at_fall  = dram_we_n;
            cas_low_cnt = 0;
            if (first_cas)
               check(ras_low_cnt == RAH + 1, "R2 row-to-column delay", ras_low_cnt, RAH + 1);
            else
               check(cas_high_cnt >= CASP, "R6 column precharge", cas_high_cnt, CASP);
            first_cas = 1'b0;
            if (!dram_we_n) begin
               check(p_we == 1'b0, "R3 early write", int'(p_we), 0);
               mem_m[int'({m_row, m_col})] = dram_din;
            end
            m_rd = mem_m.exists(int'({m_row, m_col})) ? mem_m[int'({m_row, m_col})] : 1'b0;
         end else if (!dram_cas_n) begin
            cas_low_cnt++;
            check(dram_we_n == we_at_fall, "R4 write enable steady", int'(dram_we_n), int'(we_at_fall));
         end
         if (!p_cas && dram_cas_n) begin
            cas_rises++;
            check(cas_low_cnt + 1 == CASL, "R4 column strobe width", cas_low_cnt + 1, CASL);
            cas_high_cnt = 1;
         end else if (dram_cas_n) begin
            cas_high_cnt++;
         end
         p_ras = dram_ras_n;
         p_cas = dram_cas_n;
         p_we  = dram_we_n;
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   // wait for acceptance and for the column strobe to rise, then check
   task automatic finish_req(input logic wr, input logic [2*PW-1:0] addr,
                             input logic wd, input int rb, input int cb,
                             input logic new_ras);
      int g;
      logic exp;
      g = 0;
      while (!req_ready && g < 400) begin tick(); g++; end
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      g = 0;
      while (cas_rises == cb && g < 400) begin tick(); g++; end
      if (wr) begin
         sh[int'(addr)] = wd;
      end else begin
         exp = sh.exists(int'(addr)) ? sh[int'(addr)] : 1'b0;
         check(rd_valid == 1'b1, "R4 read valid timing", int'(rd_valid), 1);
         check(rd_data == exp, "R3 read back data", int'(rd_data), int'(exp));
      end
      if (new_ras)
         check(ras_falls - rb == 1, "R7 new row strobe", ras_falls - rb, 1);
      else
         check(ras_falls - rb == 0, "R5 page hit no row strobe", ras_falls - rb, 0);
   endtask

   task automatic run_vec(input logic wr, input logic [2*PW-1:0] addr,
                          input logic wd, input logic new_ras);
      int rb, cb;
      rb = ras_falls;
      cb = cas_rises;
      req_write = wr;
      req_addr  = addr;
      req_wdata = wd;
      req_valid = 1'b1;
      #1;
      finish_req(wr, addr, wd, rb, cb, new_ras);
   endtask

   task automatic wait_ack();
      int g;
      g = 0;
      while (!ref_ack && g < 400) begin tick(); g++; end
      check(ref_ack == 1'b1, "R8 refresh ack", int'(ref_ack), 1);
   endtask

   // {write, addr[13:0], wdata, expect_new_row_strobe}
   localparam logic [16:0] VEC [10] = '{
      {1'b1, 14'h0105, 1'b1, 1'b1},
      {1'b1, 14'h0107, 1'b0, 1'b0},
      {1'b0, 14'h0105, 1'b0, 1'b0},
      {1'b0, 14'h0107, 1'b0, 1'b0},
      {1'b1, 14'h2A33, 1'b1, 1'b1},
      {1'b1, 14'h2A7F, 1'b1, 1'b0},
      {1'b0, 14'h0105, 1'b0, 1'b1},
      {1'b0, 14'h2A7F, 1'b0, 1'b1},
      {1'b1, 14'h3F80, 1'b1, 1'b1},
      {1'b0, 14'h3F80, 1'b0, 1'b0}
   };

   initial begin
      int rb, cb;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check(dram_ras_n == 1'b1, "R1 row strobe idle", int'(dram_ras_n), 1);
      check(dram_cas_n == 1'b1, "R1 column strobe idle", int'(dram_cas_n), 1);
      check(dram_we_n == 1'b1, "R1 write enable idle", int'(dram_we_n), 1);
      check(rd_valid == 1'b0, "R1 no read valid", int'(rd_valid), 0);
      check(req_ready == 1'b1, "R1 ready when idle", int'(req_ready), 1);

      for (int i = 0; i < 10; i++)
         run_vec(VEC[i][16], VEC[i][15:2], VEC[i][1], VEC[i][0]);

      // R9: miss offered to an open page is held off
      repeat (CASP + 2) tick();
      rb = ras_falls; cb = cas_rises;
      req_write = 1'b0; req_addr = 14'h0105; req_valid = 1'b1;
      #1;
      check(req_ready == 1'b0, "R9 ready low on page miss", int'(req_ready), 0);
      finish_req(1'b0, 14'h0105, 1'b0, rb, cb, 1'b1);

      // R8: refresh closes the open page, row 0 first
      repeat (CASP + 2) tick();
      rb = ras_falls;
      ref_grant = 1'b1;
      wait_ack();
      ref_grant = 1'b0;
      check(ras_falls - rb == 1, "R8 one refresh row strobe", ras_falls - rb, 1);
      check(m_row == 7'd0, "R8 first refresh row", int'(m_row), 0);
      check(cas_seen == 1'b0, "R8 column strobe stays high", int'(cas_seen), 0);
      check(dram_ras_n == 1'b1, "R8 page closed after refresh", int'(dram_ras_n), 1);
      run_vec(1'b0, 14'h0105, 1'b0, 1'b1);

      // R8: refresh wins over a pending hit
      repeat (CASP + 2) tick();
      rb = ras_falls; cb = cas_rises;
      req_write = 1'b0; req_addr = 14'h0105; req_valid = 1'b1;
      ref_grant = 1'b1;
      #1;
      check(req_ready == 1'b0, "R8 grant blocks request", int'(req_ready), 0);
      wait_ack();
      ref_grant = 1'b0;
      check(m_row == 7'd1, "R8 second refresh row", int'(m_row), 1);
      finish_req(1'b0, 14'h0105, 1'b0, rb + 1, cb, 1'b1);

      // R8: refresh row counter wraps modulo 128
      for (int k = 2; k < 129; k++) begin
         tick();
         ref_grant = 1'b1;
         wait_ack();
         ref_grant = 1'b0;
         if (k == 127)
            check(m_row == 7'd127, "R8 last refresh row", int'(m_row), 127);
         if (k == 128)
            check(m_row == 7'd0, "R8 refresh row wrap", int'(m_row), 0);
      end

      repeat (RP + 2) tick();
      check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle at end", 0, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule